// File: doc/BRIEF.md
# Carry-Save Multiply-Accumulate Processing Element

This block is one cell of an output-stationary matrix-multiply mesh. Each cycle it takes a signed operand from its left neighbour and one from its upper neighbour. It multiplies them with a radix-4 recoded multiplier and adds the product into a running total. The operands move on to the right and downward one cycle later. The running total is never resolved into plain binary inside the cell. It is kept as a pair of vectors, a pseudo-sum and a shifted carry, whose modular sum is the true value. The pair is updated through two cascaded 3:2 compressors, so no carry ripples across the word. Conversion to binary is left to a single adder at the foot of each column, outside this cell.

The cell holds two such pairs. A one-bit propagate select in the incoming control word decides their roles. One pair is the computing pair, and it feeds the single shared accumulator. The other is the shifting pair: it loads whatever arrives from the cell above and presents its contents to the cell below. Flipping the select swaps the roles. A finished total then moves down the column while a preload (bias) value, previously shifted in, becomes the starting point of the next accumulation.

The control word is registered and passed downward unchanged. It carries the select, an accumulate enable and a rounding shift amount. The shift amount is used only by logic below the array.

Top module: `cs_mac_pe`

## Requirements
- R1: `a_out` equals the `a_in` value of the previous cycle, and `b_out` equals the previous `b_in`.
- R2: `ctl_out` equals the previous `ctl_in`, all bits unchanged. The fields are: bit 0 = propagate select, bit 1 = accumulate enable, bits 6:2 = shift amount.
- R3: The product is the exact two's-complement product of the signed 8-bit operands, including the extremes -128 x -128 = 16384 and -128 x 127 = -16256.
- R4: When the enable is 1, the value of the computing pair (sum plus carry, modulo 2^W) grows by a_in x b_in in that cycle.
- R5: When the enable is 0, both vectors of the computing pair keep their values, whatever the operands are.
- R6: With select 0, pair 0 computes and pair 1 loads `d_sum_in`/`d_car_in`. With select 1, the roles are swapped: pair 1 computes and pair 0 loads.
- R7: `d_sum_out`/`d_car_out` show the raw vectors of the pair that the current select makes the shifting pair. While the select stays the same, they repeat the previous cycle's `d_sum_in`/`d_car_in`.
- R8: A value shifted into a pair becomes the start value that later products are added to, so reading the pair back gives D + sum of A x B.
- R9: During reset all registered outputs and both pairs read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 8 | Signed operand from the left |
| b_in | input | 8 | Signed operand from above |
| ctl_in | input | 7 | Control word: select, enable, shift amount |
| d_sum_in | input | 32 | Pseudo-sum vector shifted in from above |
| d_car_in | input | 32 | Carry vector shifted in from above |
| a_out | output | 8 | Registered operand to the right |
| b_out | output | 8 | Registered operand downward |
| ctl_out | output | 7 | Registered control word downward |
| d_sum_out | output | 32 | Pseudo-sum of the shifting pair, downward |
| d_car_out | output | 32 | Carry of the shifting pair, downward |

## Verification
The properties assume that the control word is stable and known at every rising edge. They also assume that the incoming pair is already a valid redundant encoding, because only its modular sum has meaning. The operands may take any 8-bit value, including -128. The stimulus drives every input a fixed delay after the rising edge. It includes directed operand extremes, enable pulses carrying large operands, and a long pseudo-random run in which the select and enable change freely. A model of both pairs follows every cycle. It compares raw vectors when the shifting pair was last written by a shift, and modular values when the pair was last written by the accumulator.

// File: rtl/cs_mac_pe.sv
module cs_mac_pe #(
  parameter int IN_W = 8,
  parameter int W    = 32,
  parameter int SH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IN_W-1:0] a_in,
  input  logic [IN_W-1:0] b_in,
  input  logic [SH_W+1:0] ctl_in,
  input  logic [W-1:0]    d_sum_in,
  input  logic [W-1:0]    d_car_in,
  output logic [IN_W-1:0] a_out,
  output logic [IN_W-1:0] b_out,
  output logic [SH_W+1:0] ctl_out,
  output logic [W-1:0]    d_sum_out,
  output logic [W-1:0]    d_car_out
);
  localparam int NPP = IN_W / 2;
  localparam int NV  = NPP + 1;

  function automatic logic [W-1:0] xor3(input logic [W-1:0] x, y, z);
    return x ^ y ^ z;
  endfunction

  function automatic logic [W-1:0] cy(input logic [W-1:0] x, y, z);
    logic [W-1:0] m;
    m = (x & y) | (x & z) | (y & z);
    return {m[W-2:0], 1'b0};
  endfunction

  logic [W-1:0]    aext;
  logic [IN_W:0]   bx;
  logic [W-1:0]    vec [NV];
  logic [W-1:0]    ts  [NV-1];
  logic [W-1:0]    tc  [NV-1];
  logic [NPP-1:0]  negs;
  logic [W-1:0]    negv;

  assign aext = {{(W-IN_W){a_in[IN_W-1]}}, a_in};
  assign bx   = {b_in, 1'b0};

  for (genvar i = 0; i < NPP; i++) begin : g_booth
    logic [2:0]   t;
    logic         one, two, neg;
    logic [W-1:0] base;
    assign t       = bx[2*i+2:2*i];
    assign one     = t[0] ^ t[1];
    assign two     = (t == 3'b011) || (t == 3'b100);
    assign neg     = t[2] & ~(t[1] & t[0]);
    assign base    = one ? aext : (two ? {aext[W-2:0], 1'b0} : '0);
    assign vec[i]  = (neg ? ~base : base) << (2*i);
    assign negs[i] = neg;
  end

  always_comb begin
    negv = '0;
    for (int i = 0; i < NPP; i++) negv[2*i] = negs[i];
  end
  assign vec[NPP] = negv;

  assign ts[0] = vec[0];
  assign tc[0] = vec[1];
  for (genvar k = 1; k < NV-1; k++) begin : g_tree
    assign ts[k] = xor3(ts[k-1], tc[k-1], vec[k+1]);
    assign tc[k] = cy(ts[k-1], tc[k-1], vec[k+1]);
  end

  logic         prop, en;
  logic [W-1:0] acc0_s, acc0_c, acc1_s, acc1_c;
  logic [W-1:0] op_s, op_c, m_s, m_c, nx_s, nx_c;

  assign prop = ctl_in[0];
  assign en   = ctl_in[1];

  assign op_s = prop ? acc1_s : acc0_s;
  assign op_c = prop ? acc1_c : acc0_c;
  assign m_s  = xor3(ts[NV-2], tc[NV-2], op_s);
  assign m_c  = cy(ts[NV-2], tc[NV-2], op_s);
  assign nx_s = xor3(m_s, m_c, op_c);
  assign nx_c = cy(m_s, m_c, op_c);

  assign d_sum_out = prop ? acc0_s : acc1_s;
  assign d_car_out = prop ? acc0_c : acc1_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_out   <= '0;
      b_out   <= '0;
      ctl_out <= '0;
      acc0_s  <= '0;
      acc0_c  <= '0;
      acc1_s  <= '0;
      acc1_c  <= '0;
    end else begin
      a_out   <= a_in;
      b_out   <= b_in;
      ctl_out <= ctl_in;
      if (!prop) begin
        if (en) begin
          acc0_s <= nx_s;
          acc0_c <= nx_c;
        end
        acc1_s <= d_sum_in;
        acc1_c <= d_car_in;
      end else begin
        if (en) begin
          acc1_s <= nx_s;
          acc1_c <= nx_c;
        end
        acc0_s <= d_sum_in;
        acc0_c <= d_car_in;
      end
    end
  end
endmodule

// File: rtl/cs_mac_pe_sva.sv
module cs_mac_pe_sva #(
  parameter int IN_W = 8,
  parameter int W    = 32,
  parameter int SH_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [IN_W-1:0] a_in,
  input logic [IN_W-1:0] b_in,
  input logic [SH_W+1:0] ctl_in,
  input logic [W-1:0]    d_sum_in,
  input logic [W-1:0]    d_car_in,
  input logic [IN_W-1:0] a_out,
  input logic [IN_W-1:0] b_out,
  input logic [SH_W+1:0] ctl_out,
  input logic [W-1:0]    d_sum_out,
  input logic [W-1:0]    d_car_out,
  input logic [W-1:0]    p0_s,
  input logic [W-1:0]    p0_c,
  input logic [W-1:0]    p1_s,
  input logic [W-1:0]    p1_c
);
  logic                     seen;
  logic signed [2*IN_W-1:0] pr;
  logic [W-1:0]             prodw, v0, v1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  assign pr    = $signed(a_in) * $signed(b_in);
  assign prodw = {{(W-2*IN_W){pr[2*IN_W-1]}}, pr};
  assign v0    = p0_s + p0_c;
  assign v1    = p1_s + p1_c;

  assert_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (a_out == $past(a_in)) && (b_out == $past(b_in)));

  assert_ctl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ctl_out == $past(ctl_in));

  assert_acc0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_in[1] && !ctl_in[0]) |=> v0 == $past(v0 + prodw));

  assert_acc1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_in[1] && ctl_in[0]) |=> v1 == $past(v1 + prodw));

  assert_hold0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_in[1] && !ctl_in[0]) |=> $stable(p0_s) && $stable(p0_c));

  assert_hold1_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_in[1] && ctl_in[0]) |=> $stable(p1_s) && $stable(p1_c));

  assert_load1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_in[0] |=> (p1_s == $past(d_sum_in)) && (p1_c == $past(d_car_in)));

  assert_load0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_in[0] |=> (p0_s == $past(d_sum_in)) && (p0_c == $past(d_car_in)));

  assert_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && (ctl_in[0] == $past(ctl_in[0])))
      |-> (d_sum_out == $past(d_sum_in)) && (d_car_out == $past(d_car_in)));
endmodule

bind cs_mac_pe cs_mac_pe_sva #(.IN_W(IN_W), .W(W), .SH_W(SH_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .ctl_in(ctl_in),
  .d_sum_in(d_sum_in), .d_car_in(d_car_in), .a_out(a_out), .b_out(b_out),
  .ctl_out(ctl_out), .d_sum_out(d_sum_out), .d_car_out(d_car_out),
  .p0_s(acc0_s), .p0_c(acc0_c), .p1_s(acc1_s), .p1_c(acc1_c)
);

// File: tb/cs_mac_pe_bench.sv
module cs_mac_pe_bench;
  localparam int IN_W = 8;
  localparam int W    = 32;
  localparam int SH_W = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [IN_W-1:0] a_in = '0, b_in = '0, a_out, b_out;
  logic [SH_W+1:0] ctl_in = '0, ctl_out;
  logic [W-1:0]    d_sum_in = '0, d_car_in = '0, d_sum_out, d_car_out;

  always #5 clk = ~clk;

  cs_mac_pe #(.IN_W(IN_W), .W(W), .SH_W(SH_W)) u_cs_mac_pe (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .ctl_in(ctl_in),
    .d_sum_in(d_sum_in), .d_car_in(d_car_in), .a_out(a_out), .b_out(b_out),
    .ctl_out(ctl_out), .d_sum_out(d_sum_out), .d_car_out(d_car_out)
  );

  typedef struct {
    int           cyc;
    int           kind;
    logic [W-1:0] v0;
    logic [W-1:0] v1;
    string        req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  logic [W-1:0] mval [2];
  logic [W-1:0] mraw_s [2];
  logic [W-1:0] mraw_c [2];
  bit           mraw [2];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    logic [W-1:0] tot;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      e = q.pop_front();
      tot = d_sum_out + d_car_out;
      case (e.kind)
        0: check(tot == e.v0, e.req, "pair value", tot, e.v0);
        1: check(W'(a_out) == e.v0, e.req, "a_out", W'(a_out), e.v0);
        2: check(W'(b_out) == e.v0, e.req, "b_out", W'(b_out), e.v0);
        3: check(W'(ctl_out) == e.v0, e.req, "ctl_out", W'(ctl_out), e.v0);
        default: begin
          check(d_sum_out == e.v0, e.req, "d_sum_out", d_sum_out, e.v0);
          check(d_car_out == e.v1, e.req, "d_car_out", d_car_out, e.v1);
        end
      endcase
    end
  end

  task automatic step(input logic [7:0] a, input logic [7:0] b, input logic [4:0] sh,
                      input bit en, input bit prop, input logic [W-1:0] ds,
                      input logic [W-1:0] dc, input string req);
    int p;
    int ob;
    int cp;
    @(posedge clk);
    #2;
    a_in = a; b_in = b; ctl_in = {sh, en, prop}; d_sum_in = ds; d_car_in = dc;
    ob = prop ? 0 : 1;
    cp = prop ? 1 : 0;
    if (mraw[ob]) q.push_back('{cyc, 4, mraw_s[ob], mraw_c[ob], "R7"});
    else          q.push_back('{cyc, 0, mval[ob], '0, req});
    q.push_back('{cyc + 1, 1, W'(a), '0, "R1"});
    q.push_back('{cyc + 1, 2, W'(b), '0, "R1"});
    q.push_back('{cyc + 1, 3, W'({sh, en, prop}), '0, "R2"});
    if (en) begin
      p = int'($signed(a)) * int'($signed(b));
      mval[cp] = mval[cp] + W'(p);
      mraw[cp] = 0;
    end
    mval[ob]   = ds + dc;
    mraw_s[ob] = ds;
    mraw_c[ob] = dc;
    mraw[ob]   = 1;
  endtask

  initial begin
    #(100000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned s;
    for (int i = 0; i < 2; i++) begin
      mval[i] = '0; mraw_s[i] = '0; mraw_c[i] = '0; mraw[i] = 1;
    end
    repeat (3) @(posedge clk);
    #2;
    check(W'(a_out) == 0, "R9", "a_out in reset", W'(a_out), '0);
    check(W'(b_out) == 0, "R9", "b_out in reset", W'(b_out), '0);
    check(W'(ctl_out) == 0, "R9", "ctl_out in reset", W'(ctl_out), '0);
    check(d_sum_out == 0, "R9", "d_sum_out in reset", d_sum_out, '0);
    check(d_car_out == 0, "R9", "d_car_out in reset", d_car_out, '0);
    rst_n = 1'b1;

    // R8: preload pair 0 with 1000, then accumulate products on top of it
    step(8'd0, 8'd0, 5'd0, 1'b0, 1'b1, 32'd1000, 32'd0, "R8");
    step(8'd3, 8'd4, 5'd1, 1'b1, 1'b0, 32'h0101_0101, 32'd1, "R4");
    step(8'h80, 8'h80, 5'd2, 1'b1, 1'b0, 32'h0202_0202, 32'd2, "R4");
    step(8'h80, 8'h7f, 5'd4, 1'b1, 1'b0, 32'h0303_0303, 32'd3, "R4");
    step(8'h7f, 8'h7f, 5'd8, 1'b1, 1'b0, 32'h0404_0404, 32'd4, "R4");
    step(8'hf9, 8'd5, 5'd16, 1'b1, 1'b0, 32'h0505_0505, 32'd5, "R4");
    step(8'd0, 8'h9d, 5'd31, 1'b1, 1'b0, 32'h0606_0606, 32'd6, "R4");
    step(8'd0, 8'd0, 5'd0, 1'b0, 1'b1, 32'd0, 32'd0, "R8");

    // R3: operand extremes from a zero start (16384 - 16256 = 128)
    step(8'd0, 8'd0, 5'd0, 1'b0, 1'b1, 32'd0, 32'd0, "R3");
    step(8'h80, 8'h80, 5'd0, 1'b1, 1'b0, 32'd0, 32'd0, "R3");
    step(8'h80, 8'h7f, 5'd0, 1'b1, 1'b0, 32'd0, 32'd0, "R3");
    step(8'd0, 8'd0, 5'd0, 1'b0, 1'b1, 32'd0, 32'd0, "R3");

    // R5 and R6: pair 1 preloaded in redundant form, enable pulses with large operands
    step(8'd0, 8'd0, 5'd0, 1'b0, 1'b0, 32'hffff_fe00, 32'h0000_0010, "R6");
    step(8'd5, 8'd6, 5'd3, 1'b1, 1'b1, 32'h1111_1111, 32'h2222_2222, "R5");
    step(8'd100, 8'd100, 5'd3, 1'b0, 1'b1, 32'h3333_3333, 32'h0, "R5");
    step(8'hfd, 8'd9, 5'd3, 1'b1, 1'b1, 32'h0, 32'h4444_4444, "R5");
    step(8'h80, 8'h80, 5'd3, 1'b0, 1'b1, 32'h5, 32'h6, "R5");
    step(8'h80, 8'h81, 5'd3, 1'b0, 1'b1, 32'h7, 32'h8, "R5");
    step(8'd0, 8'd0, 5'd0, 1'b0, 1'b0, 32'd0, 32'd0, "R5");
    step(8'd0, 8'd0, 5'd0, 1'b0, 1'b1, 32'd0, 32'd0, "R6");

    // R6 / R4 / R7: pseudo-random roles, enables and operands
    s = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      step(s[7:0], s[15:8], s[23:19], s[17] | s[18], s[16] ^ s[29],
           s ^ 32'h5a5a_5a5a, {s[15:0], s[31:16]}, "R6");
    end
    step(8'd0, 8'd0, 5'd0, 1'b0, 1'b0, 32'd0, 32'd0, "R6");
    step(8'd0, 8'd0, 5'd0, 1'b0, 1'b1, 32'd0, 32'd0, "R6");
    step(8'd0, 8'd0, 5'd0, 1'b0, 1'b0, 32'd0, 32'd0, "R6");
    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule